// File: doc/BRIEF.md
# Gated Single-Scan Conversion Queue Sequencer

This block walks one queue of conversion commands stored in a small command table. Each entry selects an analog channel. Software arms the queue by setting a single-scan enable bit. While an external gate input is high, the block runs through the table once from the first entry. For each entry it sends a one-cycle conversion request to an external converter and waits for that converter's one-cycle done pulse. The returned result is stored in the result slot that has the same index as the command.

A scan ends in one of two ways. It finishes normally when an entry carries its end-of-queue marker, or when the last table entry has been converted. A scan is cut short when the gate is found low at a conversion boundary. Either way the enable bit is cleared, so software has to arm again for the next gate-open period. A normal finish raises a completion flag. A cut-short scan raises a separate abort flag. A readable index records the last command whose conversion completed, which shows how far an aborted scan got. Both flags are cleared by writing one to them.

A command written to the table has three fields: the channel in bits [CHAN_W-1:0], a pause marker in bit CHAN_W, and the end-of-queue marker in bit CHAN_W+1. The pause marker has no effect in this mode.

Top module: `gated_scan_seq`

## Requirements
- R1: After reset, `scan_en_o`, `done_flag_o`, `abort_flag_o` and `conv_req_o` are 0 and `last_idx_o` is 0.
- R2: No conversion is requested unless the enable bit is set and `gate_i` is high. An arming write is `cfg_we` with `cfg_wdata[0]`=1. When that write is taken at clock edge k while the gate is high, `conv_req_o` is high in the cycle after edge k+1. When the write is taken while the gate is low, no request appears until the gate rises.
- R3: Each command produces exactly one single-cycle `conv_req_o` pulse. The pulse carries the command's channel field on `conv_chan_o`. Commands are issued in index order. The next request follows only after `conv_done_i` for the previous one.
- R4: The result that arrives with each `conv_done_i` is stored in the slot with the same index as its command, and it can be read at `res_rd_data_o` for index `res_rd_idx`.
- R5: A scan finishes on the done of an entry whose bit CHAN_W+1 is 1, or on the done of index DEPTH-1. At that edge `done_flag_o` is set and `scan_en_o` is cleared. This completion takes precedence when the gate is low at the same done.
- R6: When `gate_i` is low at the done edge of a command that does not end the queue, the scan stops. `abort_flag_o` is set, `scan_en_o` is cleared, and no further request is issued.
- R7: The gate level is looked at only on done edges. A low pulse that begins and ends between two done pulses does not stop the scan.
- R8: A command whose pause bit (bit CHAN_W) is set is converted like any other. No flag is raised and execution continues with the next index.
- R9: `last_idx_o` shows the index of the most recently completed conversion.
- R10: Every scan starts at index 0, including a scan that follows an aborted one. After a scan ends, no request is issued while the gate stays high until software arms again.
- R11: Writing `cfg_wdata[1]`=1 clears `done_flag_o`, and writing `cfg_wdata[2]`=1 clears `abort_flag_o`. A zero in either bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | External gate; high opens the gate |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Bit 0 arms; bit 1 clears the done flag; bit 2 clears the abort flag |
| cmd_we | input | 1 | Command table write strobe |
| cmd_idx | input | IDX_W | Command table write index |
| cmd_wdata | input | CHAN_W+2 | Command: channel, pause marker, end-of-queue marker |
| res_rd_idx | input | IDX_W | Result slot read index |
| res_rd_data_o | output | RES_W | Result slot read data |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | CHAN_W | Channel for the request |
| conv_done_i | input | 1 | One-cycle conversion done |
| conv_result_i | input | RES_W | Conversion result, valid together with done |
| scan_en_o | output | 1 | Single-scan enable bit |
| done_flag_o | output | 1 | Completion flag |
| abort_flag_o | output | 1 | Gate-closed abort flag |
| last_idx_o | output | IDX_W | Index of the last completed conversion |

## Verification
The hardest case to reach is the gate closing at exactly the done edge that ends the queue. In that case completion must win over abort. The bench's converter model lowers the gate on the same cycle it raises the N-th done. A directed scan places the end-of-queue marker at index N-1 to hit this case. Random scans vary the abort position, the converter latency and the marker position. A second directed case pulses the gate low while a conversion is outstanding, which shows that the gate is sampled only at conversion boundaries.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_e;

   localparam int unsigned CFG_W         = 3;
   localparam int unsigned CFG_ARM       = 0;
   localparam int unsigned CFG_CLR_DONE  = 1;
   localparam int unsigned CFG_CLR_ABORT = 2;
endpackage

// File: rtl/gsq_entry_store.sv
module gsq_entry_store #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] view [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            ent_q <= wr_data;
         end
      end
      assign view[i] = ent_q;
   end

   assign rd_data = view[rd_idx];
endmodule

// File: rtl/gsq_gate_sync.sv
module gsq_gate_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic gate_o
);
   if (STAGES == 0) begin : g_direct
      assign gate_o = gate_i;
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
   end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= gate_i;
            for (int k = 1; k < STAGES; k++) begin
               sh_q[k] <= sh_q[k-1];
            end
         end
      end
      assign gate_o = sh_q[STAGES-1];
   end
endmodule

// File: rtl/gsq_seq_ctrl.sv
module gsq_seq_ctrl
   import gsq_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int CHAN_W = 6,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic              cfg_we_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   input  logic [CHAN_W:0]   ccw_i,
   output logic [IDX_W-1:0]  ccw_idx_o,
   output logic              conv_req_o,
   output logic [CHAN_W-1:0] conv_chan_o,
   input  logic              conv_done_i,
   output logic              res_we_o,
   output logic              scan_en_o,
   output logic              done_flag_o,
   output logic              abort_flag_o,
   output logic [IDX_W-1:0]  last_idx_o
);
   sq_state_e        st_q, st_d;
   logic [IDX_W-1:0] ptr_q, ptr_d;
   logic [IDX_W-1:0] last_q;
   logic             en_q, done_q, abort_q;
   logic             fin, abt, at_end;
   logic             arm_wr, clr_done, clr_abort;

   assign arm_wr    = cfg_we_i && cfg_wdata_i[CFG_ARM];
   assign clr_done  = cfg_we_i && cfg_wdata_i[CFG_CLR_DONE];
   assign clr_abort = cfg_we_i && cfg_wdata_i[CFG_CLR_ABORT];

   assign at_end      = ccw_i[CHAN_W] || (ptr_q == IDX_W'(DEPTH - 1));
   assign conv_req_o  = (st_q == SQ_ISSUE);
   assign conv_chan_o = ccw_i[CHAN_W-1:0];
   assign ccw_idx_o   = ptr_q;

   always_comb begin
      st_d     = st_q;
      ptr_d    = ptr_q;
      fin      = 1'b0;
      abt      = 1'b0;
      res_we_o = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (en_q && gate_i) begin
               st_d  = SQ_ISSUE;
               ptr_d = '0;
            end
         end
         SQ_ISSUE: st_d = SQ_WAIT;
         SQ_WAIT: begin
            if (conv_done_i) begin
               res_we_o = 1'b1;
               if (at_end) begin
                  fin  = 1'b1;
                  st_d = SQ_IDLE;
               end else if (!gate_i) begin
                  abt  = 1'b1;
                  st_d = SQ_IDLE;
               end else begin
                  ptr_d = ptr_q + IDX_W'(1);
                  st_d  = SQ_ISSUE;
               end
            end
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         ptr_q   <= '0;
         last_q  <= '0;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ptr_q <= ptr_d;
         if (res_we_o) last_q <= ptr_q;
         if (fin || abt)  en_q <= 1'b0;
         else if (arm_wr) en_q <= 1'b1;
         if (fin)            done_q <= 1'b1;
         else if (clr_done)  done_q <= 1'b0;
         if (abt)            abort_q <= 1'b1;
         else if (clr_abort) abort_q <= 1'b0;
      end
   end

   assign scan_en_o    = en_q;
   assign done_flag_o  = done_q;
   assign abort_flag_o = abort_q;
   assign last_idx_o   = last_q;

   AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |-> en_q); // R2
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |=> !conv_req_o); // R3
   AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> !en_q); // R5
   AST_ABORT_ON_LOW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_q) |-> (!en_q && !$past(gate_i))); // R6
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req_o && $past(st_q == SQ_IDLE)) |-> (ccw_idx_o == '0)); // R10
endmodule

// File: rtl/gated_scan_seq.sv
module gated_scan_seq
   import gsq_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int CHAN_W      = 6,
   parameter int RES_W       = 10,
   parameter int SYNC_STAGES = 0,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CMD_W      = CHAN_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              cmd_we,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic [IDX_W-1:0]  res_rd_idx,
   output logic [RES_W-1:0]  res_rd_data_o,
   output logic              conv_req_o,
   output logic [CHAN_W-1:0] conv_chan_o,
   input  logic              conv_done_i,
   input  logic [RES_W-1:0]  conv_result_i,
   output logic              scan_en_o,
   output logic              done_flag_o,
   output logic              abort_flag_o,
   output logic [IDX_W-1:0]  last_idx_o
);
   localparam int STORE_W = CHAN_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("gated_scan_seq: DEPTH must be a power of two of at least 2");
   end
   if (CHAN_W < 1 || RES_W < 1) begin : g_bad_width
      $error("gated_scan_seq: CHAN_W and RES_W must be positive");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("gated_scan_seq: SYNC_STAGES must lie in 0..3");
   end

   logic               gate_s;
   logic [STORE_W-1:0] ccw_rd;
   logic [STORE_W-1:0] ccw_wr;
   logic [IDX_W-1:0]   ccw_idx;
   logic               res_we;
   logic               unused_pause_bit;

   // the pause marker is dropped on write: it never changes execution here
   assign ccw_wr           = {cmd_wdata[CHAN_W+1], cmd_wdata[CHAN_W-1:0]};
   assign unused_pause_bit = cmd_wdata[CHAN_W];

   gsq_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .gate_o(gate_s)
   );

   gsq_entry_store #(.DEPTH(DEPTH), .DATA_W(STORE_W)) u_cmd_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cmd_we), .wr_idx(cmd_idx), .wr_data(ccw_wr),
      .rd_idx(ccw_idx), .rd_data(ccw_rd)
   );

   gsq_entry_store #(.DEPTH(DEPTH), .DATA_W(RES_W)) u_res_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(res_we), .wr_idx(ccw_idx), .wr_data(conv_result_i),
      .rd_idx(res_rd_idx), .rd_data(res_rd_data_o)
   );

   gsq_seq_ctrl #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_s),
      .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .ccw_i(ccw_rd), .ccw_idx_o(ccw_idx),
      .conv_req_o(conv_req_o), .conv_chan_o(conv_chan_o),
      .conv_done_i(conv_done_i), .res_we_o(res_we),
      .scan_en_o(scan_en_o), .done_flag_o(done_flag_o),
      .abort_flag_o(abort_flag_o), .last_idx_o(last_idx_o)
   );
endmodule

// File: tb/gated_scan_seq_tb_top.sv
module gated_scan_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 64;
   localparam int CHAN_W = 6;
   localparam int RES_W  = 10;
   localparam int IDX_W  = 6;
   localparam int CMD_W  = CHAN_W + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              gate = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_wdata = '0;
   logic              cmd_we = 1'b0;
   logic [IDX_W-1:0]  cmd_idx = '0;
   logic [CMD_W-1:0]  cmd_wdata = '0;
   logic [IDX_W-1:0]  res_rd_idx = '0;
   logic [RES_W-1:0]  res_rd_data;
   logic              conv_req;
   logic [CHAN_W-1:0] conv_chan;
   logic              conv_done = 1'b0;
   logic [RES_W-1:0]  conv_result = '0;
   logic              scan_en, done_f, abort_f;
   logic [IDX_W-1:0]  last_idx;

   int checks = 0, fails = 0;
   logic [CMD_W-1:0]  tbl [DEPTH];
   logic [CHAN_W-1:0] chan_log [DEPTH];
   logic [RES_W-1:0]  exp_res [DEPTH];
   int lat = 0, abort_after = 0, dones_in_scan = 0, req_count = 0;
   int busy = 0, lat_left = 0, serial = 0;
   logic [CHAN_W-1:0] chan_q = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gated_scan_seq #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .RES_W(RES_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .gate_i(gate),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata),
      .res_rd_idx(res_rd_idx), .res_rd_data_o(res_rd_data),
      .conv_req_o(conv_req), .conv_chan_o(conv_chan),
      .conv_done_i(conv_done), .conv_result_i(conv_result),
      .scan_en_o(scan_en), .done_flag_o(done_f),
      .abort_flag_o(abort_f), .last_idx_o(last_idx)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eoq_index();
      for (int i = 0; i < DEPTH; i++)
         if (tbl[i][CHAN_W+1]) return i;
      return DEPTH - 1;
   endfunction

   // converter model: answers each request after 'lat' idle cycles
   initial forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (busy != 0) begin
         if (lat_left == 0) begin
            serial++;
            conv_result = RES_W'(serial * 37 + int'(chan_q));
            conv_done = 1'b1;
            busy = 0;
            if (dones_in_scan < DEPTH) exp_res[dones_in_scan] = conv_result;
            dones_in_scan++;
            if (abort_after != 0 && dones_in_scan == abort_after) gate = 1'b0;
         end else begin
            lat_left--;
         end
      end
      if (conv_req) begin
         chk("R3 one outstanding", busy, 0);
         busy = 1;
         chan_q = conv_chan;
         lat_left = lat;
         if (req_count < DEPTH) chan_log[req_count] = conv_chan;
         req_count++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic cfg_write(logic [2:0] bits);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = bits;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic fill_table(int eoq_pos, bit all_pause);
      for (int i = 0; i < DEPTH; i++) begin
         tbl[i][CHAN_W-1:0] = CHAN_W'($urandom);
         tbl[i][CHAN_W]     = all_pause ? 1'b1 : 1'($urandom);
         tbl[i][CHAN_W+1]   = (i == eoq_pos);
         @(negedge clk);
         cmd_we = 1'b1;
         cmd_idx = IDX_W'(i);
         cmd_wdata = tbl[i];
      end
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic prepare(int abort_k, int latency, int eoq_pos, bit all_pause);
      fill_table(eoq_pos, all_pause);
      lat = latency;
      abort_after = abort_k;
      dones_in_scan = 0;
      req_count = 0;
   endtask

   // gate high and arm: the request must appear one cycle after enable rises
   task automatic start_now();
      gate = 1'b1;
      cfg_write(3'b001);
      #1 chk("R2 no request yet", conv_req, 0);
      @(negedge clk);
      #1 chk("R2 request next cycle", conv_req, 1);
   endtask

   task automatic finish_check(int abort_k);
      int e, n, rc;
      bit complete;
      for (int t = 0; t < 20000 && scan_en; t++) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
      e = eoq_index();
      complete = (abort_k == 0) || (abort_k > e);
      n = complete ? e + 1 : abort_k;
      chk("R5 done flag", done_f, complete);
      chk("R6 abort flag", abort_f, !complete);
      chk("R5 R6 enable cleared", scan_en, 0);
      chk("R9 last index", last_idx, n - 1);
      chk("R3 request count", req_count, n);
      for (int i = 0; i < n; i++)
         chk("R3 channel order", chan_log[i], tbl[i][CHAN_W-1:0]);
      chk("R10 first channel from index 0", chan_log[0], tbl[0][CHAN_W-1:0]);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         res_rd_idx = IDX_W'(i);
         #1 chk("R4 result slot", res_rd_data, exp_res[i]);
      end
      if (complete) begin
         rc = req_count;
         repeat (6) @(negedge clk);
         #1 chk("R10 no rescan without re-arm", req_count, rc);
      end
      gate = 1'b0;
      cfg_write(3'b110);
      #1 chk("R11 flags cleared", {done_f, abort_f}, 2'b00);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 enable", scan_en, 0);
      chk("R1 flags", {done_f, abort_f}, 2'b00);
      chk("R1 request", conv_req, 0);
      chk("R1 last index", last_idx, 0);
      rst_n = 1'b1;

      // arm with gate low: waits for the gate
      prepare(0, 1, 7, 1'b0);
      gate = 1'b0;
      cfg_write(3'b001);
      repeat (8) @(negedge clk);
      #1 chk("R2 gate low holds off", req_count, 0);
      chk("R2 enable stays set", scan_en, 1);
      gate = 1'b1;
      @(negedge clk);
      #1 chk("R2 starts when gate opens", conv_req, 1);
      finish_check(0);

      // pause markers everywhere: converted, no flag, no stall (R8)
      prepare(0, 0, 12, 1'b1);
      start_now();
      finish_check(0);

      // no end marker: runs to last entry (R5)
      prepare(0, 0, -1, 1'b0);
      start_now();
      finish_check(0);

      // gate closes on the very done that ends the queue: completion wins (R5)
      prepare(6, 2, 5, 1'b0);
      start_now();
      finish_check(6);

      // abort mid-queue then new scan restarts at index 0 (R6, R10)
      prepare(4, 1, 20, 1'b0);
      start_now();
      finish_check(4);
      prepare(0, 0, 9, 1'b0);
      start_now();
      finish_check(0);

      // short gate-low pulse between dones is missed (R7)
      prepare(0, 5, 10, 1'b0);
      start_now();
      @(negedge clk); gate = 1'b0;
      @(negedge clk); gate = 1'b1;
      finish_check(0);

      // selective flag clearing (R11)
      prepare(0, 0, 2, 1'b0);
      start_now();
      for (int t = 0; t < 2000 && scan_en; t++) @(negedge clk);
      cfg_write(3'b100);
      #1 chk("R11 zero bit leaves done flag", done_f, 1);
      cfg_write(3'b010);
      #1 chk("R11 done flag cleared", done_f, 0);
      gate = 1'b0;

      // constrained random scans
      for (int s = 0; s < 30; s++) begin
         int ep, ak;
         ep = int'($urandom_range(0, DEPTH));
         if (ep == DEPTH) ep = -1;
         ak = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 40));
         prepare(ak, int'($urandom_range(0, 4)), ep, 1'b0);
         start_now();
         finish_check(ak);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule